// File: doc/BRIEF.md
# External Sync Lock and Vertical Reset

This block picks the timing source for a camera timing generator. It looks at a mode strap and at the activity on the shared vertical/composite sync input. From these it decides whether the sync generator runs freely (internal) or is slaved to an outside source. It also works out when the vertical counter must be reloaded and which field comes next.

There are two external modes. In composite mode, the block finds the vertical interval inside the incoming composite sync by the width of its low pulses. It then reloads the vertical counter a fixed number of lines later: 259 lines for the 525-line standard and 309 lines for the 625-line standard. In separate-VD/HD mode, it reloads on the first line start after the falling edge of the external VD. In both modes the field is taken from where the vertical edge lands inside the locked line: an edge in the first half gives odd, an edge in the second half gives even. The block also limits scan options that cannot run under external sync.

The horizontal lock is done elsewhere and reaches this block as a one-cycle line-start pulse. An open pin arrives as a static level: the sync input idles high and the mode strap idles low.

Top module: `extsync_lock`

## Requirements
- R1: While reset is held, `ext_o`, `vreset_o` and `field_odd_o` are all 0.
- R2: When `esync_i` is 1, the block enters separate-VD/HD mode and `ext_o` reads 1 from the second clock edge after the strap is sampled high.
- R3: When `esync_i` is 0, the block is in composite mode (`ext_o`=1) if a falling edge was seen on `vr_sync_i` within the last ACT_LINES line starts. Once ACT_LINES line starts pass with no falling edge, it is in internal mode (`ext_o`=0).
- R4: In composite mode, a low pulse on `vr_sync_i` is a vertical event only if it is sampled low on more than THRESH = LINE_LEN*3/8 consecutive edges. The event is accepted at the edge after the (THRESH+1)-th low sample. A pulse of THRESH samples or fewer does nothing.
- R5: In composite mode, `vreset_o` rises after the EIA_VLINES-th `hd_ref_i` line start that follows the accepted event when `ccir_i`=0, and after the CCIR_VLINES-th when `ccir_i`=1.
- R6: In separate-VD/HD mode, the event is accepted at the edge after the first low sample of `vr_sync_i`. `vreset_o` rises after the first line start that follows acceptance.
- R7: The phase of an event is the number of clock edges from the last line start to the first low sample of the pulse. A phase below LINE_LEN/2 gives `field_odd_o`=1 and any other phase gives 0. `field_odd_o` is updated together with `vreset_o` and changes at no other time.
- R8: While a reset countdown is pending, new events are ignored. A VD held low for many lines gives one reset, and the VD period is not checked.
- R9: A line start sampled at the same edge that accepts the event is not counted.
- R10: Falling back to internal mode cancels a pending countdown. `vreset_o` never rises in internal mode.
- R11: `nonint_o` = `nonint_req_i` except in composite mode, where it is 0. `frame_acc_o` = `frame_req_i`, except that it is 0 when `ext_o` and `nonint_o` are both 1.
- R12: `vreset_o` is high for exactly one cycle per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| esync_i | input | 1 | Mode strap: 1 selects separate VD/HD sync |
| vr_sync_i | input | 1 | Composite sync or external VD, active low, idles high |
| hd_ref_i | input | 1 | One-cycle pulse at each locked line start |
| ccir_i | input | 1 | 0 selects the 525-line standard, 1 the 625-line standard |
| nonint_req_i | input | 1 | Non-interlaced scan request |
| frame_req_i | input | 1 | Frame accumulation request |
| ext_o | output | 1 | 1 when timing follows an external source |
| vreset_o | output | 1 | One-cycle vertical counter reload strobe |
| field_odd_o | output | 1 | Field preset, 1 for odd, loaded with the strobe |
| nonint_o | output | 1 | Granted non-interlaced scan |
| frame_acc_o | output | 1 | Granted frame accumulation |

## Verification
Event acceptance and line-start counting can land on the same clock edge. This happens when a VD edge arrives in the last clock of a line. The bench sweeps the VD fall over every phase of a short line, so the phase-31 case puts acceptance and a line start on one edge. That case must produce its reset one full line later, not at once. The same sweep checks the odd/even split at both sides of mid-line, and each reset cycle is predicted from the bench's own count of line starts.

// File: rtl/xsl_pkg.sv
package xsl_pkg;

  typedef enum logic [1:0] {
    XS_INT  = 2'd0,
    XS_COMP = 2'd1,
    XS_VDHD = 2'd2
  } xs_mode_e;

  // Low-pulse length (in samples beyond which) a pulse is vertical.
  function automatic int unsigned serr_thresh(int unsigned line_len);
    return (line_len * 3) / 8;
  endfunction

  // Edge in the first half of a locked line marks the odd field.
  function automatic logic first_half(int unsigned ph, int unsigned line_len);
    return ph < (line_len / 2);
  endfunction

  // Number of line starts between event acceptance and reload.
  function automatic int unsigned reset_lines(xs_mode_e m, logic ccir,
                                              int unsigned eia_n,
                                              int unsigned ccir_n);
    if (m == XS_VDHD) return 1;
    return ccir ? ccir_n : eia_n;
  endfunction

endpackage

// File: rtl/xsl_mode_detect.sv
module xsl_mode_detect
  import xsl_pkg::*;
#(
  parameter int ACT_LINES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     esync_i,
  input  logic     vr_fall_i,
  input  logic     line_start_i,
  output xs_mode_e mode_o
);
  localparam int ACT_W = $clog2(ACT_LINES + 1);

  logic             es_q;
  logic [ACT_W-1:0] act_cnt;
  xs_mode_e         mode_q;
  logic             act_live;

  assign act_live = act_cnt < ACT_W'(ACT_LINES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q    <= 1'b0;
      act_cnt <= ACT_W'(ACT_LINES);
      mode_q  <= XS_INT;
    end else begin
      es_q <= esync_i;
      if (vr_fall_i) act_cnt <= '0;
      else if (line_start_i && act_live) act_cnt <= act_cnt + ACT_W'(1);
      if (es_q)          mode_q <= XS_VDHD;
      else if (act_live) mode_q <= XS_COMP;
      else               mode_q <= XS_INT;
    end
  end

  assign mode_o = mode_q;

  AST_VDHD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    es_q |=> (mode_o == XS_VDHD)); // R2

endmodule

// File: rtl/xsl_vsep.sv
module xsl_vsep
  import xsl_pkg::*;
#(
  parameter int LINE_LEN = 606
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vr_i,
  input  logic                        line_start_i,
  output logic                        vr_fall_o,
  output logic                        serr_o,
  output logic [$clog2(LINE_LEN)-1:0] phase_o,
  output logic [$clog2(LINE_LEN)-1:0] fall_phase_o
);
  localparam int PH_W   = $clog2(LINE_LEN);
  localparam int THRESH = int'(serr_thresh(LINE_LEN));
  localparam int LW     = $clog2(THRESH + 2);

  logic            s1, s2;
  logic [LW-1:0]   lowcnt;
  logic [PH_W-1:0] ph, fph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      lowcnt <= '0;
      ph     <= '0;
      fph    <= '0;
    end else begin
      s1 <= vr_i;
      s2 <= s1;
      if (s1) lowcnt <= '0;
      else if (lowcnt <= LW'(THRESH)) lowcnt <= lowcnt + LW'(1);
      if (line_start_i) ph <= '0;
      else if (ph != PH_W'(LINE_LEN - 1)) ph <= ph + PH_W'(1);
      if (vr_fall_o) fph <= ph;
    end
  end

  assign vr_fall_o    = s2 & ~s1;
  assign serr_o       = ~s1 & (lowcnt == LW'(THRESH));
  assign phase_o      = ph;
  assign fall_phase_o = fph;

  AST_SERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |=> !serr_o); // R4
  AST_SERR_NOT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    vr_fall_o |-> !serr_o); // R4

endmodule

// File: rtl/xsl_vtimer.sv
module xsl_vtimer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             evt_i,
  input  logic             evt_odd_i,
  input  logic [CNT_W-1:0] evt_lines_i,
  input  logic             line_start_i,
  output logic             vreset_o,
  output logic             field_odd_o
);
  logic             busy;
  logic             odd_r;
  logic [CNT_W-1:0] cnt, lines_r;
  logic             last_line;

  assign last_line = (cnt == lines_r - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      odd_r       <= 1'b0;
      cnt         <= '0;
      lines_r     <= '0;
      vreset_o    <= 1'b0;
      field_odd_o <= 1'b0;
    end else begin
      vreset_o <= 1'b0;
      if (!run_i) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (evt_i) begin
          busy    <= 1'b1;
          cnt     <= '0;
          lines_r <= evt_lines_i;
          odd_r   <= evt_odd_i;
        end
      end else if (line_start_i) begin
        if (last_line) begin
          busy        <= 1'b0;
          vreset_o    <= 1'b1;
          field_odd_o <= odd_r;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_VRESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vreset_o |=> !vreset_o); // R12
  AST_NO_VRESET_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !vreset_o); // R10
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vreset_o |-> $stable(field_odd_o)); // R7

endmodule

// File: rtl/extsync_lock.sv
module extsync_lock
  import xsl_pkg::*;
#(
  parameter int LINE_LEN    = 606,
  parameter int ACT_LINES   = 4,
  parameter int EIA_VLINES  = 259,
  parameter int CCIR_VLINES = 309
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esync_i,
  input  logic vr_sync_i,
  input  logic hd_ref_i,
  input  logic ccir_i,
  input  logic nonint_req_i,
  input  logic frame_req_i,
  output logic ext_o,
  output logic vreset_o,
  output logic field_odd_o,
  output logic nonint_o,
  output logic frame_acc_o
);
  localparam int PH_W  = $clog2(LINE_LEN);
  localparam int MAXV  = (EIA_VLINES > CCIR_VLINES) ? EIA_VLINES : CCIR_VLINES;
  localparam int CNT_W = $clog2(MAXV + 1);

  xs_mode_e        mode;
  logic            vr_fall, serr;
  logic [PH_W-1:0] ph_live, ph_fall, evt_phase;
  logic            evt, evt_odd, run;
  logic [CNT_W-1:0] evt_lines;

  xsl_vsep #(.LINE_LEN(LINE_LEN)) u_vsep (
    .clk          (clk),
    .rst_n        (rst_n),
    .vr_i         (vr_sync_i),
    .line_start_i (hd_ref_i),
    .vr_fall_o    (vr_fall),
    .serr_o       (serr),
    .phase_o      (ph_live),
    .fall_phase_o (ph_fall)
  );

  xsl_mode_detect #(.ACT_LINES(ACT_LINES)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .esync_i      (esync_i),
    .vr_fall_i    (vr_fall),
    .line_start_i (hd_ref_i),
    .mode_o       (mode)
  );

  // Composite: event is the vertical-width pulse, phase held from its fall.
  // VD/HD: event is the VD fall itself, phase taken live.
  always_comb begin
    evt       = 1'b0;
    evt_phase = ph_live;
    if (mode == XS_COMP) begin
      evt       = serr;
      evt_phase = ph_fall;
    end else if (mode == XS_VDHD) begin
      evt       = vr_fall;
      evt_phase = ph_live;
    end
  end

  assign evt_odd   = first_half(32'(evt_phase), LINE_LEN);
  assign evt_lines = CNT_W'(reset_lines(mode, ccir_i, EIA_VLINES, CCIR_VLINES));
  assign run       = (mode != XS_INT);

  xsl_vtimer #(.CNT_W(CNT_W)) u_vtimer (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .evt_i        (evt),
    .evt_odd_i    (evt_odd),
    .evt_lines_i  (evt_lines),
    .line_start_i (hd_ref_i),
    .vreset_o     (vreset_o),
    .field_odd_o  (field_odd_o)
  );

  assign ext_o       = run;
  assign nonint_o    = nonint_req_i & (mode != XS_COMP);
  assign frame_acc_o = frame_req_i & ~(ext_o & nonint_o);

  AST_COMP_INTERLACED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XS_COMP) |-> !nonint_o); // R11

endmodule

// File: tb/extsync_lock_tb.sv
module extsync_lock_tb_top;
  localparam int L    = 32;
  localparam int THR  = 12;   // three eighths of a 32-clock line
  localparam int NEIA = 259;
  localparam int NCC  = 309;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esync_i = 1'b0, vr_sync_i = 1'b1, hd_ref_i = 1'b0, ccir_i = 1'b0;
  logic nonint_req_i = 1'b0, frame_req_i = 1'b0;
  logic ext_o, vreset_o, field_odd_o, nonint_o, frame_acc_o;

  extsync_lock #(.LINE_LEN(L), .ACT_LINES(4), .EIA_VLINES(NEIA),
                 .CCIR_VLINES(NCC)) dut_i (
    .clk(clk), .rst_n(rst_n), .esync_i(esync_i), .vr_sync_i(vr_sync_i),
    .hd_ref_i(hd_ref_i), .ccir_i(ccir_i), .nonint_req_i(nonint_req_i),
    .frame_req_i(frame_req_i), .ext_o(ext_o), .vreset_o(vreset_o),
    .field_odd_o(field_odd_o), .nonint_o(nonint_o), .frame_acc_o(frame_acc_o));

  always #4 clk = ~clk;

  int cyc = 0;
  int kind = 0, vs = 0, w = 0, bw = 14;
  int vr_cnt = 0, vr_last = -1, dbl = 0;
  logic vr_field = 1'b0, prev_vr = 1'b0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic wave(int c);
    if (kind == 1) return !(c >= vs && c < vs + w);
    if (kind == 2) begin
      if (c >= vs && c < vs + 96) return ((c - vs) % 16) >= bw;
      return (c % L) >= 3;
    end
    return 1'b1;
  endfunction

  function automatic int next_start(int e);
    return (e / L + 1) * L;
  endfunction

  // Inputs for the next edge are driven at the falling edge; outputs sampled there.
  always @(negedge clk) begin
    if (vreset_o) begin
      vr_cnt   = vr_cnt + 1;
      vr_last  = cyc;
      vr_field = field_odd_o;
      if (prev_vr) dbl = dbl + 1;
    end
    prev_vr   = vreset_o;
    hd_ref_i  = ((cyc + 1) % L) == 0;
    vr_sync_i = wave(cyc + 1);
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int c0, e, ex;
    repeat (3) @(negedge clk);
    chk("R1 ext", ext_o, 0);
    chk("R1 vreset", vreset_o, 0);
    chk("R1 field", field_odd_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Internal: all inputs idle.
    wait_until(cyc + 6 * L);
    @(negedge clk);
    chk("R3 internal ext", ext_o, 0);
    nonint_req_i = 1; frame_req_i = 1; #1;
    chk("R11 internal nonint", nonint_o, 1);
    chk("R11 internal frame", frame_acc_o, 1);

    // Separate VD/HD mode.
    esync_i = 1'b1;
    wait_until(cyc + 4);
    @(negedge clk);
    chk("R2 ext", ext_o, 1);
    chk("R11 vdhd nonint", nonint_o, 1);
    chk("R11 vdhd frame blocked", frame_acc_o, 0);
    nonint_req_i = 0; #1;
    chk("R11 vdhd frame interlaced", frame_acc_o, 1);

    for (int p = 0; p < L; p++) begin
      @(posedge clk); #1;
      c0 = vr_cnt;
      vs = next_start(cyc) + 2 * L + p; w = 70; kind = 1;
      ex = next_start(vs + 1);
      wait_until(ex + L);
      chk((p == L - 1) ? "R9 count" : "R6 count", vr_cnt - c0, 1);
      chk((p == L - 1) ? "R9 cycle" : "R6 cycle", vr_last, ex);
      chk("R7 field", vr_field, (p < L / 2) ? 1 : 0);
    end

    // Long VD, several lines low.
    @(posedge clk); #1;
    c0 = vr_cnt;
    vs = next_start(cyc) + 2 * L + 5; w = 10 * L; kind = 1;
    ex = next_start(vs + 1);
    wait_until(vs + w + 3 * L);
    chk("R8 long vd count", vr_cnt - c0, 1);
    chk("R8 long vd cycle", vr_last, ex);

    // Composite mode: run hsync only first.
    kind = 0; esync_i = 1'b0;
    wait_until(cyc + 6 * L);
    @(posedge clk); #1;
    vs = 1 << 30; bw = 14; kind = 2;
    nonint_req_i = 1; frame_req_i = 1;
    wait_until(cyc + 3 * L);
    @(negedge clk);
    chk("R3 composite ext", ext_o, 1);
    chk("R11 comp nonint", nonint_o, 0);
    chk("R11 comp frame", frame_acc_o, 1);

    // EIA, odd field.
    @(posedge clk); #1;
    c0 = vr_cnt; ccir_i = 0;
    vs = next_start(cyc) + 2 * L;
    e = vs + THR + 1; ex = next_start(e) + (NEIA - 1) * L;
    wait_until(ex + L);
    chk("R5 eia count", vr_cnt - c0, 1);
    chk("R5 eia cycle", vr_last, ex);
    chk("R7 eia field", vr_field, 1);

    // CCIR, even field.
    @(posedge clk); #1;
    c0 = vr_cnt; ccir_i = 1;
    vs = next_start(cyc) + 2 * L + L / 2;
    e = vs + THR + 1; ex = next_start(e) + (NCC - 1) * L;
    wait_until(ex + L);
    chk("R5 ccir count", vr_cnt - c0, 1);
    chk("R5 ccir cycle", vr_last, ex);
    chk("R7 ccir field", vr_field, 0);

    // Pulses exactly at threshold must not count.
    @(posedge clk); #1;
    c0 = vr_cnt; ccir_i = 0; bw = THR;
    vs = next_start(cyc) + 2 * L;
    wait_until(vs + (NEIA + 10) * L);
    chk("R4 short pulses", vr_cnt - c0, 0);

    // Pending countdown cancelled when the source goes away.
    @(posedge clk); #1;
    c0 = vr_cnt; bw = 14;
    vs = next_start(cyc) + 2 * L;
    e = vs + THR + 1; ex = next_start(e) + (NEIA - 1) * L;
    wait_until(vs + 100);
    kind = 0;
    wait_until(ex + L);
    chk("R10 cancel count", vr_cnt - c0, 0);
    @(negedge clk);
    chk("R10 ext dropped", ext_o, 0);
    chk("R12 single-cycle strobe", dbl, 0);

    finish_run();
  end

endmodule